// File: doc/BRIEF.md
# Interrupt File Priority Selector

This block holds the per-identity pending and enable state of a single interrupt file. Incoming message writes set pending bits, and a small register port gives software access to the pending and enable words, a threshold, a delivery switch and a top-interrupt register. Every cycle, a priority search over the registered state finds the smallest identity that is both pending and enabled and that passes the threshold filter. The result drives a single interrupt request line toward the hart.

Software reads the top-interrupt register to learn which identity to service. It claims that identity by writing any value to the same register, which clears only that identity's pending bit. The state array is sized by `NUM_IDS`, which must be a multiple of 32. Identity 0 exists only as a placeholder and never takes part. Register reads are combinational from the address. Writes take effect at the next rising clock edge.

Top module: `intfile_prio_sel`

## Requirements
- R1: Identity 0 is never pending and never enabled. Bit 0 of pending word 0 and bit 0 of enable word 0 always read 0, even after a write of all ones.
- R2: An incoming message with `msi_valid` high sets the pending bit of identity `msi_data` when 1 <= `msi_data` < `NUM_IDS`. A value of 0, or a value of `NUM_IDS` or more, changes nothing.
- R3: Among the identities that are pending, enabled and inside the threshold window, the one with the smallest number is reported.
- R4: When the threshold is 0 or at least `NUM_IDS`, every identity from 1 to `NUM_IDS`-1 is searched. Otherwise only identities strictly below the threshold are searched.
- R5: The top-interrupt register (address 2) reads the reported identity in bits [31:16] and again in bits [15:0]. It reads 0 when no identity qualifies. Reading it has no side effect.
- R6: A write to address 2 ignores its data. When an identity is being reported, the write clears that identity's pending bit and no other. When nothing is reported, the write changes nothing.
- R7: When a claim and an incoming message for the same identity arrive in the same cycle, the identity stays pending.
- R8: The delivery register (address 0) keeps only bit 0 of a write; its other bits read 0. `irq_o` is high exactly when delivery is 1 and some identity qualifies. It follows the registered state with no further delay, so it drops right after the clock edge of a claim that leaves nothing qualifying.
- R9: The threshold register (address 1) keeps only the low `$clog2(NUM_IDS)+1` bits of a write; its higher bits read 0.
- R10: Pending word k sits at address 16+k and enable word k at address 32+k. Bit j of word k holds identity 32*k+j. A write replaces the whole word. Addresses that are not mapped read 0.
- R11: While `rst` is high at a clock edge, all pending, enable, threshold and delivery state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msi_valid | input | 1 | Incoming message strobe |
| msi_data | input | 32 | Identity carried by the message |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_o | output | 1 | Interrupt request toward the hart |

## Verification
The bench targets the threshold edges: a threshold equal to a pending identity (a design off by one would still report that identity), a threshold of exactly `NUM_IDS`, and a wide write that must be masked. It claims with junk data and with nothing reported, and it lands a claim and a message on the same identity in one cycle; a design with the wrong precedence loses that interrupt. It writes all ones to word 0 and sends message values of 0 and beyond range, which a faulty design would turn into phantom identities. Randomized traffic then checks the lowest-wins order and the delivery gating of `irq_o` against a model.

// File: rtl/intfile_pkg.sv
package intfile_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned TOP_SHIFT = 16;
  localparam int unsigned A_DLV     = 0;
  localparam int unsigned A_THR     = 1;
  localparam int unsigned A_TOP     = 2;
  localparam int unsigned A_PEND    = 16;
  localparam int unsigned A_EN      = 32;
endpackage

// File: rtl/intfile_bits.sv
module intfile_bits #(
  parameter int unsigned NUM_IDS = 64,
  localparam int unsigned NUM_WORDS = NUM_IDS / 32,
  localparam int unsigned WIDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int unsigned ID_W = $clog2(NUM_IDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_pend,
  input  logic               wr_en,
  input  logic [WIDX_W-1:0]  word_idx,
  input  logic [31:0]        wdata,
  input  logic               msi_set,
  input  logic [ID_W-1:0]    msi_id,
  input  logic               clr_valid,
  input  logic [ID_W-1:0]    clr_id,
  output logic [NUM_IDS-1:0] pend_q,
  output logic [NUM_IDS-1:0] en_q
);
  logic [NUM_IDS-1:0] pend_d, en_d;

  always_comb begin
    pend_d = pend_q;
    en_d   = en_q;
    if (clr_valid) pend_d[clr_id] = 1'b0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (word_idx == WIDX_W'(w)) begin
        if (wr_pend) pend_d[w*32 +: 32] = wdata;
        if (wr_en)   en_d[w*32 +: 32]   = wdata;
      end
    end
    if (msi_set) pend_d[msi_id] = 1'b1;  // set wins over claim
    pend_d[0] = 1'b0;
    en_d[0]   = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
    end
  end

  AST_ID0_QUIET: assert property (@(posedge clk) disable iff (rst)
    !pend_q[0] && !en_q[0]); // R1
  AST_MSI_SETS: assert property (@(posedge clk) disable iff (rst)
    msi_set |=> pend_q[$past(msi_id)]); // R7
  AST_CLAIM_DROPS: assert property (@(posedge clk) disable iff (rst)
    (clr_valid && !wr_pend && !(msi_set && msi_id == clr_id)) |=> !pend_q[$past(clr_id)]); // R6
endmodule

// File: rtl/intfile_prio_enc.sv
module intfile_prio_enc #(
  parameter int unsigned NUM_IDS = 64,
  localparam int unsigned ID_W = $clog2(NUM_IDS),
  localparam int unsigned THR_W = ID_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IDS-1:0] pend,
  input  logic [NUM_IDS-1:0] en,
  input  logic [THR_W-1:0]   thr,
  output logic               found,
  output logic [ID_W-1:0]    top_id
);
  logic               all_in;
  logic [NUM_IDS-1:0] elig;

  assign all_in = (thr == '0) || (thr >= THR_W'(NUM_IDS));
  assign elig[0] = 1'b0;

  for (genvar i = 1; i < NUM_IDS; i++) begin : g_elig
    assign elig[i] = pend[i] & en[i] & (all_in | (THR_W'(i) < thr));
  end

  always_comb begin
    found  = 1'b0;
    top_id = '0;
    for (int i = NUM_IDS - 1; i >= 1; i--) begin
      if (elig[i]) begin
        found  = 1'b1;
        top_id = ID_W'(i);
      end
    end
  end

  AST_TOP_QUALIFIES: assert property (@(posedge clk) disable iff (rst)
    found |-> (pend[top_id] && en[top_id] && top_id != '0)); // R3
endmodule

// File: rtl/intfile_prio_sel.sv
module intfile_prio_sel #(
  parameter int unsigned NUM_IDS = 64,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msi_valid,
  input  logic [31:0]       msi_data,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_o
);
  import intfile_pkg::*;

  localparam int unsigned NUM_WORDS = NUM_IDS / 32;
  localparam int unsigned WIDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int unsigned ID_W = $clog2(NUM_IDS);
  localparam int unsigned THR_W = ID_W + 1;

  logic               dlv_q;
  logic [THR_W-1:0]   thr_q;
  logic [NUM_IDS-1:0] pend_q, en_q;
  logic               found;
  logic [ID_W-1:0]    top_id;
  logic               in_pend, in_en, hit_top, msi_ok, claim;
  logic [WIDX_W-1:0]  pend_idx, en_idx, word_idx;
  logic [31:0]        top_val;

  assign in_pend  = (reg_addr >= ADDR_W'(A_PEND)) && (reg_addr < ADDR_W'(A_PEND + NUM_WORDS));
  assign in_en    = (reg_addr >= ADDR_W'(A_EN)) && (reg_addr < ADDR_W'(A_EN + NUM_WORDS));
  assign pend_idx = WIDX_W'(reg_addr - ADDR_W'(A_PEND));
  assign en_idx   = WIDX_W'(reg_addr - ADDR_W'(A_EN));
  assign word_idx = in_en ? en_idx : pend_idx;
  assign hit_top  = (reg_addr == ADDR_W'(A_TOP));
  assign msi_ok   = msi_valid && (msi_data != 32'd0) && (msi_data < 32'(NUM_IDS));
  assign claim    = reg_wr && hit_top && found;

  intfile_bits #(.NUM_IDS(NUM_IDS)) u_bits (
    .clk       (clk),
    .rst       (rst),
    .wr_pend   (reg_wr && in_pend),
    .wr_en     (reg_wr && in_en),
    .word_idx  (word_idx),
    .wdata     (reg_wdata),
    .msi_set   (msi_ok),
    .msi_id    (msi_data[ID_W-1:0]),
    .clr_valid (claim),
    .clr_id    (top_id),
    .pend_q    (pend_q),
    .en_q      (en_q)
  );

  intfile_prio_enc #(.NUM_IDS(NUM_IDS)) u_enc (
    .clk    (clk),
    .rst    (rst),
    .pend   (pend_q),
    .en     (en_q),
    .thr    (thr_q),
    .found  (found),
    .top_id (top_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dlv_q <= 1'b0;
      thr_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_W'(A_DLV)) dlv_q <= reg_wdata[0];
      if (reg_addr == ADDR_W'(A_THR)) thr_q <= reg_wdata[THR_W-1:0];
    end
  end

  assign top_val = (32'(top_id) << TOP_SHIFT) | 32'(top_id);
  assign irq_o   = dlv_q && found;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(A_DLV))      reg_rdata = {31'd0, dlv_q};
    else if (reg_addr == ADDR_W'(A_THR)) reg_rdata = 32'(thr_q);
    else if (hit_top)                    reg_rdata = top_val;
    else if (in_pend)                    reg_rdata = pend_q[pend_idx*32 +: 32];
    else if (in_en)                      reg_rdata = en_q[en_idx*32 +: 32];
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> dlv_q); // R8
  AST_THR_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (found && thr_q != '0 && thr_q < THR_W'(NUM_IDS)) |-> (THR_W'(top_id) < thr_q)); // R4
  AST_THR_MASKED: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(A_THR)) |=> (32'(thr_q) == ($past(reg_wdata) & ((32'd1 << THR_W) - 32'd1)))); // R9
  AST_MSI_RANGE: assert property (@(posedge clk) disable iff (rst)
    (msi_valid && msi_data >= 32'(NUM_IDS) && !reg_wr) |=> $stable(pend_q)); // R2
endmodule

// File: tb/intfile_prio_sel_test.sv
module intfile_prio_sel_test;
  localparam int NUM_IDS = 64;
  localparam int ADDR_W = 6;
  localparam int THR_W = 7;
  localparam int NW = NUM_IDS / 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, msi_valid, reg_wr, irq_o;
  logic [31:0] msi_data, reg_wdata, reg_rdata;
  logic [ADDR_W-1:0] reg_addr;

  intfile_prio_sel #(.NUM_IDS(NUM_IDS), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .msi_valid(msi_valid), .msi_data(msi_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  int total = 0;
  int bad = 0;
  bit m_pend[NUM_IDS];
  bit m_en[NUM_IDS];
  int m_thr;
  bit m_dlv;

  function automatic int exp_top();
    int lim;
    lim = (m_thr == 0 || m_thr > NUM_IDS) ? NUM_IDS : m_thr;
    for (int i = 1; i < lim; i++) if (m_pend[i] && m_en[i]) return i;
    return 0;
  endfunction

  function automatic logic [31:0] word_of(bit pend_sel, int k);
    logic [31:0] v = '0;
    for (int j = 0; j < 32; j++) v[j] = pend_sel ? m_pend[k*32+j] : m_en[k*32+j];
    return v;
  endfunction

  function automatic void model_step(bit mv, int md, bit wr, int addr, logic [31:0] wd);
    int tid = exp_top();
    if (wr) begin
      if (addr == 0) m_dlv = wd[0];
      else if (addr == 1) m_thr = int'(wd & 32'h7F);
      else if (addr == 2) begin if (tid != 0) m_pend[tid] = 1'b0; end
      else if (addr >= 16 && addr < 16 + NW)
        for (int j = 0; j < 32; j++) m_pend[(addr-16)*32+j] = wd[j];
      else if (addr >= 32 && addr < 32 + NW)
        for (int j = 0; j < 32; j++) m_en[(addr-32)*32+j] = wd[j];
    end
    if (mv && md > 0 && md < NUM_IDS) m_pend[md] = 1'b1;
    m_pend[0] = 1'b0;
    m_en[0] = 1'b0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(bit mv, int md, bit wr, int addr, logic [31:0] wd);
    @(negedge clk);
    msi_valid = mv; msi_data = 32'(md);
    reg_wr = wr; reg_addr = ADDR_W'(addr); reg_wdata = wd;
    @(posedge clk);
    model_step(mv, md, wr, addr, wd);
    @(negedge clk);
    msi_valid = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(int addr, output logic [31:0] v);
    reg_addr = ADDR_W'(addr);
    #1 v = reg_rdata;
  endtask

  task automatic check_top(string req);
    logic [31:0] v;
    int t = exp_top();
    rd(2, v);
    check(req, v, (32'(t) << 16) | 32'(t));
    check(req, {31'd0, irq_o}, {31'd0, m_dlv && t != 0});
  endtask

  task automatic check_word(string req, bit pend_sel, int k);
    logic [31:0] v;
    rd(pend_sel ? 16 + k : 32 + k, v);
    check(req, v, word_of(pend_sel, k));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    rst = 1'b1; msi_valid = 1'b0; msi_data = '0; reg_wr = 1'b0;
    reg_addr = '0; reg_wdata = '0;
    for (int i = 0; i < NUM_IDS; i++) begin m_pend[i] = 0; m_en[i] = 0; end
    m_thr = 0; m_dlv = 0;
    // R11: reset clears the state, even after traffic during reset
    @(negedge clk); msi_valid = 1'b1; msi_data = 32'd7;
    reg_wr = 1'b1; reg_addr = 6'd0; reg_wdata = 32'd1;
    repeat (2) @(posedge clk);
    @(negedge clk); msi_valid = 1'b0; reg_wr = 1'b0;
    rd(0, v); check("R11 delivery", v, 32'd0);
    rd(1, v); check("R11 threshold", v, 32'd0);
    check_word("R11 pending", 1, 0);
    check_top("R11 top");
    rst = 1'b0;

    // R10 R1: word writes, identity 0 bit stays zero
    step(0, 0, 1, 32, 32'hFFFF_FFFF);
    step(0, 0, 1, 33, 32'hFFFF_FFFF);
    check_word("R1 enable word0", 0, 0);
    check_word("R10 enable word1", 0, 1);
    step(0, 0, 1, 16, 32'hFFFF_FFFF);
    rd(16, v); check("R1 pending word0", v, 32'hFFFF_FFFE);
    step(0, 0, 1, 16, 32'h0);
    rd(40, v); check("R10 unmapped", v, 32'd0);

    // R2 R3 R8
    step(0, 0, 1, 0, 32'd1);
    step(1, 40, 0, 0, 0);
    step(1, 5, 0, 0, 0);
    check_top("R3 lowest wins");
    step(1, 0, 0, 0, 0);
    step(1, NUM_IDS, 0, 0, 0);
    step(1, 32'h0001_0028, 0, 0, 0);
    check_word("R2 ignored values", 1, 0);
    check_word("R2 ignored values", 1, 1);

    // R4 R9
    step(0, 0, 1, 1, 32'd5);
    check_top("R4 threshold equal excludes");
    step(0, 0, 1, 1, 32'd6);
    check_top("R4 threshold above includes");
    step(0, 0, 1, 1, 32'h0000_01C3);
    rd(1, v); check("R9 threshold mask", v, 32'h43);
    check_top("R4 large threshold");
    step(0, 0, 1, 1, NUM_IDS);
    check_top("R4 threshold equals NUM_IDS");

    // R6 R5
    step(0, 0, 1, 2, 32'hDEAD_BEEF);
    check_top("R6 claim clears reported only");
    check_word("R6 claim clears reported only", 1, 1);
    // R7: claim and message on same identity
    step(1, 40, 1, 2, 32'd0);
    check_word("R7 set wins", 1, 1);
    check_top("R7 set wins");

    // R8 delivery masking
    step(0, 0, 1, 0, 32'hFFFF_FFFE);
    rd(0, v); check("R8 delivery bit0 only", v, 32'd0);
    check_top("R8 irq gated");
    step(0, 0, 1, 0, 32'hFFFF_FFFF);
    rd(0, v); check("R8 delivery readback", v, 32'd1);
    step(0, 0, 1, 2, 32'd1);
    check_top("R8 irq drops after last claim");
    step(0, 0, 1, 2, 32'd3);
    check_word("R6 claim with nothing reported", 1, 1);
    check_top("R6 claim with nothing reported");

    // randomized traffic
    for (int n = 0; n < 800; n++) begin
      int op = int'($urandom % 8);
      int id = int'($urandom % 80);
      logic [31:0] rw = $urandom & $urandom & $urandom;
      case (op)
        0, 1: step(1, id, 0, 0, 0);
        2: step(0, 0, 1, 16 + int'($urandom % NW), rw);
        3: step(0, 0, 1, 32 + int'($urandom % NW), ~rw);
        4: step(0, 0, 1, 1, ($urandom % 3 == 0) ? 32'(id) : 32'd0);
        5: step(0, 0, 1, 0, ($urandom % 4 == 0) ? 32'd0 : 32'd1);
        6: step(0, 0, 1, 2, $urandom);
        default: step(1, exp_top(), 1, 2, $urandom);
      endcase
      check_top("R3/R4/R5/R8 random");
      if (n % 16 == 0) check_word("R10 random", 1, n % NW);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule